// File: doc/BRIEF.md
# Output Rounding, Limiting and Format Stage

This stage sits at the tail of a fixed-coefficient filter datapath. It takes the filter's wide signed accumulator and turns it into a 16-bit output word. A 3-bit resolution select sets where the effective LSB of that word lies, anywhere from bit 0 (full 16-bit precision) up to bit 7 (9 significant bits). The value is rounded to the nearest half LSB at that point, and every bit under it is forced to zero. A limiter then clamps the result to the legal range. After that, a format control chooses between two's complement and inverted offset binary.

The accumulator carries `EXT_W` fraction bits below output bit 0 and `HEAD_W` guard bits above output bit 15. The filter's -6 dB interpolating mode can only produce half-scale results, so a half-range control narrows the limiter to 15-bit bounds in that mode. The stage is one register deep. A result is captured only in a cycle that carries the input valid strobe, and the captured word is held until the next valid input.

Top module: `rsf_stage`

## Requirements
- R1: While reset is asserted, and up to the first valid input after it, `out_valid` is 0 and `out_word` is 0000h.
- R2: Output bit 0 has the weight of accumulator bit `EXT_W` (4). For `rnd_sel` = k, the stage adds 1 at accumulator bit `EXT_W`+k-1. It keeps output bits 15 down to k and outputs bits k-1 down to 0 as zero. When k is 0 all 16 bits are kept.
- R3: With `half_lim` = 0, a rounded result above +32767 output LSBs gives 7FFFh, and one below -32768 gives 8000h (two's complement view). The limiter acts after rounding, so a round-up that carries out of range is also clamped.
- R4: With `half_lim` = 1, the bounds are 3FFFh and C000h (two's complement view).
- R5: With `tc_fmt` = 1 the word is two's complement. With `tc_fmt` = 0, bit 15 is kept and bits 14 down to 0 are inverted: zero becomes 7FFFh, 4018h becomes 3FE7h, 7FFFh becomes 0000h and 8000h becomes FFFFh. This conversion is the last step, applied after the limiter.
- R6: In a cycle with `in_valid` = 0, `out_word` keeps its previous value, whatever the accumulator and control inputs do.
- R7: `out_valid` is `in_valid` delayed by one clock. The word computed from the inputs of a valid cycle appears on `out_word` after the next rising edge. `rnd_sel`, `half_lim` and `tc_fmt` are sampled together with the accumulator.
- R8: A clamped result is the bound word itself, whatever `rnd_sel` selects. A positive overflow gives 7FFFh (or 3FFFh) even when bits below the selected LSB would otherwise be zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accumulator and controls are valid this cycle |
| acc_in | input | ACC_W (24) | Signed filter accumulator |
| rnd_sel | input | 3 | Effective LSB position of the output word |
| half_lim | input | 1 | 1: limit to 15-bit bounds (-6 dB mode) |
| tc_fmt | input | 1 | 1: two's complement, 0: inverted offset binary |
| out_valid | output | 1 | `out_word` was updated at the last edge |
| out_word | output | 16 | Rounded, limited and formatted result |

## Verification
Rounding and limiting can act on the same input. An accumulator just under a bound, carrying a half-LSB fraction, is pushed over that bound by the round-up increment and must come out as the bound word, not as a wrapped value. The bench provokes this case at the low and high resolution settings, under both limit ranges and both output formats. It also provokes it alongside ordinary pseudo-random values. It judges each result against a scoreboard that computes floor-after-half-add in 64-bit integers, clamps, and then flips the low 15 bits for the offset format.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } fmt_e;

  typedef enum logic {
    LIM_FULL = 1'b0,
    LIM_HALF = 1'b1
  } lim_e;
endpackage

// File: rtl/rsf_round.sv
module rsf_round #(
  parameter int OUT_W  = 16,
  parameter int EXT_W  = 4,
  parameter int HEAD_W = 4,
  parameter int SEL_W  = 3,
  localparam int ACC_W = OUT_W + EXT_W + HEAD_W,
  localparam int RES_W = ACC_W + 1
) (
  input  logic [ACC_W-1:0]        acc_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic signed [RES_W-1:0] res_o
);
  localparam int HALF_BASE = EXT_W - 1;

  // half-LSB increment at the selected position
  function automatic logic [RES_W-1:0] half_inc(input logic [SEL_W-1:0] s);
    logic [RES_W-1:0] one;
    one = {{(RES_W-1){1'b0}}, 1'b1};
    return one << (HALF_BASE + int'(s));
  endfunction

  logic [RES_W-1:0]        acc_ext;
  logic [RES_W-1:0]        sum;
  logic signed [RES_W-1:0] scaled;
  logic [RES_W-1:0]        keep;

  assign acc_ext = {acc_i[ACC_W-1], acc_i};
  assign sum     = acc_ext + half_inc(sel_i);
  assign scaled  = $signed(sum) >>> EXT_W;

  // bits below the selected LSB are cleared
  for (genvar gi = 0; gi < RES_W; gi++) begin : g_keep
    assign keep[gi] = (gi >= int'(sel_i));
  end

  assign res_o = $signed(scaled & keep);
endmodule

// File: rtl/rsf_limit.sv
module rsf_limit #(
  parameter int OUT_W  = 16,
  parameter int EXT_W  = 4,
  parameter int HEAD_W = 4,
  localparam int ACC_W = OUT_W + EXT_W + HEAD_W,
  localparam int RES_W = ACC_W + 1
) (
  input  logic signed [RES_W-1:0] res_i,
  input  logic                    half_i,
  output logic [OUT_W-1:0]        lim_o,
  output logic                    ovf_hi_o,
  output logic                    ovf_lo_o
);
  localparam logic signed [RES_W-1:0] FULL_HI = (RES_W'(1) <<< (OUT_W-1)) - RES_W'(1);
  localparam logic signed [RES_W-1:0] FULL_LO = -(RES_W'(1) <<< (OUT_W-1));
  localparam logic signed [RES_W-1:0] HALF_HI = (RES_W'(1) <<< (OUT_W-2)) - RES_W'(1);
  localparam logic signed [RES_W-1:0] HALF_LO = -(RES_W'(1) <<< (OUT_W-2));

  function automatic logic [OUT_W-1:0] clamp(input logic signed [RES_W-1:0] v,
                                             input logic signed [RES_W-1:0] hi,
                                             input logic signed [RES_W-1:0] lo);
    if (v > hi)      return hi[OUT_W-1:0];
    else if (v < lo) return lo[OUT_W-1:0];
    else             return v[OUT_W-1:0];
  endfunction

  logic signed [RES_W-1:0] hi_b;
  logic signed [RES_W-1:0] lo_b;

  assign hi_b     = half_i ? HALF_HI : FULL_HI;
  assign lo_b     = half_i ? HALF_LO : FULL_LO;
  assign ovf_hi_o = (res_i > hi_b);
  assign ovf_lo_o = (res_i < lo_b);
  assign lim_o    = clamp(res_i, hi_b, lo_b);
endmodule

// File: rtl/rsf_format.sv
module rsf_format #(
  parameter int OUT_W = 16
) (
  input  logic [OUT_W-1:0] lim_i,
  input  logic             tc_i,
  output logic [OUT_W-1:0] word_o
);
  function automatic logic [OUT_W-1:0] to_fmt(input logic [OUT_W-1:0] v, input logic tc);
    return {v[OUT_W-1], v[OUT_W-2:0] ^ {(OUT_W-1){~tc}}};
  endfunction

  assign word_o = to_fmt(lim_i, tc_i);
endmodule

// File: rtl/rsf_stage.sv
module rsf_stage #(
  parameter int OUT_W  = 16,
  parameter int EXT_W  = 4,
  parameter int HEAD_W = 4,
  parameter int SEL_W  = 3,
  localparam int ACC_W = OUT_W + EXT_W + HEAD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [SEL_W-1:0] rnd_sel,
  input  logic             half_lim,
  input  logic             tc_fmt,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word
);
  import rsf_pkg::*;
  localparam int RES_W = ACC_W + 1;
  localparam logic [OUT_W-1:0] TOP_POS  = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] TOP_NEG  = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] HALF_POS = {2'b00, {(OUT_W-2){1'b1}}};
  localparam logic [OUT_W-1:0] HALF_NEG = {2'b11, {(OUT_W-2){1'b0}}};

  logic signed [RES_W-1:0] rounded;
  logic [OUT_W-1:0]        limited;
  logic [OUT_W-1:0]        formatted;
  logic                    sat_hi;
  logic                    sat_lo;
  logic                    sat_any;
  logic [OUT_W-1:0]        low_mask;

  rsf_round #(.OUT_W(OUT_W), .EXT_W(EXT_W), .HEAD_W(HEAD_W), .SEL_W(SEL_W)) u_round (
    .acc_i (acc_in),
    .sel_i (rnd_sel),
    .res_o (rounded)
  );

  rsf_limit #(.OUT_W(OUT_W), .EXT_W(EXT_W), .HEAD_W(HEAD_W)) u_limit (
    .res_i    (rounded),
    .half_i   (half_lim),
    .lim_o    (limited),
    .ovf_hi_o (sat_hi),
    .ovf_lo_o (sat_lo)
  );

  rsf_format #(.OUT_W(OUT_W)) u_format (
    .lim_i  (limited),
    .tc_i   (tc_fmt),
    .word_o (formatted)
  );

  // named events for the checks below
  assign sat_any  = sat_hi | sat_lo;
  assign low_mask = (OUT_W'(1) << rnd_sel) - OUT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= formatted;
    end
  end

  p_valid_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));
  p_low_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tc_fmt == FMT_TWOS && !sat_any) |=> ((out_word & $past(low_mask)) == '0));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tc_fmt == FMT_TWOS && half_lim == LIM_FULL && sat_hi) |=> (out_word == TOP_POS));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tc_fmt == FMT_TWOS && half_lim == LIM_FULL && sat_lo) |=> (out_word == TOP_NEG));
  p_half_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tc_fmt == FMT_TWOS && half_lim == LIM_HALF) |=>
      ($signed(out_word) <= $signed(HALF_POS) && $signed(out_word) >= $signed(HALF_NEG)));
  p_offset_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tc_fmt == FMT_OFFSET && acc_in == '0) |=> (out_word == TOP_POS));
endmodule

// File: tb/rsf_stage_tb.sv
module rsf_stage_tb;
  localparam int ACC_W = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [ACC_W-1:0] acc_in = '0;
  logic [2:0]       rnd_sel = '0;
  logic             half_lim = 1'b0;
  logic             tc_fmt = 1'b1;
  logic             out_valid;
  logic [15:0]      out_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] held = 16'h0000;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  rsf_stage u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in),
    .rnd_sel(rnd_sel), .half_lim(half_lim), .tc_fmt(tc_fmt),
    .out_valid(out_valid), .out_word(out_word)
  );

  // expectation: floor((v + half) / step) * 2^k, clamp, then offset flip
  function automatic logic [15:0] expect_word(input logic [ACC_W-1:0] a, input int k,
                                              input bit h, input bit tc);
    longint v, step, q, hi, lo;
    logic [15:0] r;
    v = longint'($signed(a));
    step = longint'(1) << (4 + k);
    q = v + step / 2;
    if (q < 0) q = -((-q + step - 1) / step);
    else       q = q / step;
    q = q * (longint'(1) << k);
    hi = h ? 16383 : 32767;
    lo = h ? -16384 : -32768;
    if (q > hi) q = hi;
    if (q < lo) q = lo;
    r = q[15:0];
    if (!tc) r = {r[15], ~r[14:0]};
    return r;
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic drive(input string tag, input logic [ACC_W-1:0] a, input int k,
                       input bit h, input bit tc);
    @(negedge clk);
    in_valid = 1'b1;
    acc_in   = a;
    rnd_sel  = 3'(k);
    half_lim = h;
    tc_fmt   = tc;
    exp_q.push_back(expect_word(a, k, h, tc));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      seed = next_rand(seed);
      acc_in   = seed[ACC_W-1:0];
      rnd_sel  = seed[26:24];
      half_lim = seed[27];
      tc_fmt   = seed[28];
    end
  endtask

  // monitor: result after each valid cycle, held word otherwise (R6, R7)
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R7: actual out_valid 1 expected 0 (no pending item)");
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, out_word, e);
          held = e;
        end
      end else begin
        check("R6 hold", out_word, held);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", out_word, 16'h0000);
    check("R1 reset valid", {15'd0, out_valid}, 16'h0000);
    rst_n = 1'b1;
    idle(2);

    // R2: half-LSB round-up and truncation at several positions
    drive("R2 sel0 up",   24'h000108, 0, 0, 1);
    drive("R2 sel0 down", 24'h000107, 0, 0, 1);
    drive("R2 sel3",      24'h0012C0, 3, 0, 1);
    drive("R2 sel7",      24'h0ABCDE, 7, 0, 1);
    drive("R2 sel7 neg",  24'hF54321, 7, 0, 1);
    idle(3);
    // R3: clamp, including carry from rounding
    drive("R3 pos carry", 24'h07FFF8, 0, 0, 1);
    drive("R3 pos big",   24'h3FFFFF, 2, 0, 1);
    drive("R3 neg big",   24'hF7FFF0, 0, 0, 1);
    drive("R3 edge ok",   24'h07FFF7, 0, 0, 1);
    drive("R3 neg edge",  24'hF80000, 0, 0, 1);
    // R4: 15-bit bounds
    drive("R4 half hi",   24'h040000, 0, 1, 1);
    drive("R4 half carry",24'h03FFF8, 0, 1, 1);
    drive("R4 half lo",   24'hFBFFF0, 0, 1, 1);
    drive("R4 half in",   24'h020100, 1, 1, 1);
    idle(2);
    // R5: inverted offset binary after the limiter
    drive("R5 zero",      24'h000000, 0, 0, 0);
    drive("R5 4018",      24'h040180, 0, 0, 0);
    drive("R5 pos sat",   24'h7FFFFF, 0, 0, 0);
    drive("R5 neg sat",   24'h800000, 0, 0, 0);
    drive("R5 half sat",  24'h100000, 5, 1, 0);
    // R8: bound word kept whole at coarse resolution
    drive("R8 sel7 pos",  24'h0FFFFF, 7, 0, 1);
    drive("R8 sel7 half", 24'h07FFFF, 7, 1, 1);
    drive("R8 sel4 off",  24'h0FFFF0, 4, 0, 0);
    idle(4);
    // R2-R5 mixed: pseudo-random values near and away from bounds
    for (int i = 0; i < 96; i++) begin
      logic [ACC_W-1:0] a;
      seed = next_rand(seed);
      a = seed[ACC_W-1:0];
      if (seed[29]) a = {{4{a[23]}}, a[19:0]};
      drive("R2 random", a, int'(seed[26:24]), seed[27], seed[28]);
      if (seed[31:30] == 2'b00) idle(1);
    end
    idle(4);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R7: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule